// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

The block drives one pulse-width-modulated output from an 8-bit period timer. The timer advances once every four input clocks times a selectable prescale ratio of 1, 4 or 16. It restarts from zero when it matches an 8-bit period register, so one PWM period lasts (period+1)·4·ratio clocks.

The 10-bit duty value is compared against the timer extended by two fine bits. With a ratio of 1 these come from a free-running 2-bit phase counter; with larger ratios they come from the top of the prescaler count. The output stays high for duty·ratio input clocks.

Software writes the duty high byte and low pair at any time. Both are copied into shadow storage only on the period-match edge, so a write in mid-period never shortens or stretches the current pulse. A one-clock match strobe is produced on every period end. A postscaler raises a sticky interrupt flag after every N matches.

Top module: `pwm10_top`

## Requirements
- R1: After reset the timer reads 0x00, the control readback reads 0x00, the output is low, the interrupt flag is low, and the period register holds 0xFF (a running PWM period lasts 1024 clocks at ratio 1).
- R2: Writes use `wrAddr` 0 = period, 1 = duty high byte, 2 = duty low pair (data bits 1:0), 3 = control, 4 = timer. Control bits 1:0 select the ratio (00 = 1, 01 = 4, 1x = 16), bit 2 is timer-on and bits 6:3 are the postscaler. A PWM period lasts (period+1)·4·ratio input clocks.
- R3: With duty D = {high byte, low pair} and D < 4·(period+1), the output is high for exactly D·ratio clocks per period, starting on the match edge.
- R4: With D = 0 the output stays low for the whole period.
- R5: With D ≥ 4·(period+1) the output stays high for the whole period.
- R6: A duty write takes effect only from the next period match. The shadow duty high byte changes only on a match edge.
- R7: `periodHit` is high for exactly one clock per match. The output rises only in a cycle where `periodHit` is high.
- R8: `irqFlag` is set on every (postscaler+1)-th match and stays set until `flagClr` is pulsed.
- R9: With timer-on at 0, the timer value and the output level do not change.
- R10: A timer write loads the timer directly. Control readback bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 8 | Write data |
| flagClr | input | 1 | Clears the interrupt flag |
| pwmOut | output | 1 | PWM output |
| periodHit | output | 1 | One-clock period-match strobe |
| irqFlag | output | 1 | Sticky postscaled interrupt flag |
| shadowDuty | output | 8 | Latched duty high byte |
| timerCount | output | 8 | Current timer value |
| ctrlReg | output | 8 | Control register readback |

## Verification
The bench sweeps duty over zero, one, small values, one below the full count, exactly the full count and the maximum code, at prescale ratios 1, 4 and 16. It checks the high time and the period length in clocks against arithmetic expectations. An off-by-one in the fine compare would show as high times of D·ratio plus or minus one step. Bad fine-bit selection would break the ratio-4 and ratio-16 cases, and a missing overflow guard would make duty at or past the full count clear the output. A duty rewrite in mid-period catches a design without shadow buffering, which would cut the running pulse short. Postscaler spacing, flag stickiness and the freeze on timer-off are checked at the ports.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int ADDR_W = 3;
  localparam int PS_W   = 4;
  localparam int FINE_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTYHI = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTYLO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TIMER  = 3'd4;

  typedef struct packed {
    logic              fineAdv;
    logic              timerAdv;
    logic [FINE_W-1:0] fineLo;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm10_ctrl.sv
module pwm10_ctrl
  import pwm10_pkg::*;
#(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerOn,
  input  logic [1:0]        psSel,
  input  logic [POST_W-1:0] postSel,
  input  logic              tmrWr,
  input  logic              wrap,
  input  logic              flagClr,
  output pwmStrobe_t        strobe,
  output logic              irqFlag
);
  logic [FINE_W-1:0] phase;
  logic [PS_W-1:0]   psCnt;
  logic [PS_W-1:0]   psMax;
  logic [POST_W-1:0] postCnt;
  logic              tick;

  assign tick = timerOn && (phase == {FINE_W{1'b1}});

  always_comb begin
    case (psSel)
      2'b00: begin
        psMax          = '0;
        strobe.fineAdv = timerOn && !tmrWr;
        strobe.fineLo  = phase;
      end
      2'b01: begin
        psMax          = PS_W'(3);
        strobe.fineAdv = tick && !tmrWr;
        strobe.fineLo  = psCnt[1:0];
      end
      default: begin
        psMax          = PS_W'(15);
        strobe.fineAdv = tick && !tmrWr && (psCnt[1:0] == 2'b11);
        strobe.fineLo  = psCnt[3:2];
      end
    endcase
    strobe.timerAdv = tick && !tmrWr && (psCnt == psMax);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      psCnt   <= '0;
      postCnt <= '0;
      irqFlag <= 1'b0;
    end else begin
      if (timerOn) phase <= phase + 1'b1;
      if (tmrWr) psCnt <= '0;
      else if (tick) psCnt <= (psCnt == psMax) ? '0 : psCnt + 1'b1;
      if (wrap) postCnt <= (postCnt == postSel) ? '0 : postCnt + 1'b1;
      if (wrap && (postCnt == postSel)) irqFlag <= 1'b1;
      else if (flagClr) irqFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm10_dp.sv
module pwm10_dp
  import pwm10_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [TMR_W-1:0]  wrData,
  input  pwmStrobe_t        strobe,
  output logic              tmrWr,
  output logic              wrap,
  output logic              timerOn,
  output logic [1:0]        psSel,
  output logic [POST_W-1:0] postSel,
  output logic              pwmOut,
  output logic              periodHit,
  output logic [TMR_W-1:0]  shadowDuty,
  output logic [TMR_W-1:0]  timerCount,
  output logic [TMR_W-1:0]  ctrlReg
);
  localparam int DUTY_W = TMR_W + FINE_W;
  localparam int CTRL_W = POST_W + 3;

  logic [TMR_W-1:0]  periodR, dutyHiR, tmr, shadowHi;
  logic [FINE_W-1:0] dutyLoR, shadowLo;
  logic [CTRL_W-1:0] ctrlBits;
  logic [DUTY_W-1:0] fineNext, dutyLive, dutyNew;
  logic              clearHit;

  assign tmrWr    = wrEn && (wrAddr == ADDR_TIMER);
  assign timerOn  = ctrlBits[2];
  assign psSel    = ctrlBits[1:0];
  assign postSel  = ctrlBits[CTRL_W-1:3];
  assign fineNext = {tmr, strobe.fineLo} + 1'b1;
  assign dutyLive = {shadowHi, shadowLo};
  assign dutyNew  = {dutyHiR, dutyLoR};
  assign wrap     = strobe.timerAdv && (tmr == periodR);
  assign clearHit = strobe.fineAdv && !wrap && (fineNext == dutyLive);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodR   <= '1;
      dutyHiR   <= '0;
      dutyLoR   <= '0;
      ctrlBits  <= '0;
      tmr       <= '0;
      shadowHi  <= '0;
      shadowLo  <= '0;
      pwmOut    <= 1'b0;
      periodHit <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          ADDR_PERIOD: periodR  <= wrData;
          ADDR_DUTYHI: dutyHiR  <= wrData;
          ADDR_DUTYLO: dutyLoR  <= wrData[FINE_W-1:0];
          ADDR_CTRL:   ctrlBits <= wrData[CTRL_W-1:0];
          default: ;
        endcase
      end
      if (tmrWr) tmr <= wrData;
      else if (wrap) tmr <= '0;
      else if (strobe.timerAdv) tmr <= tmr + 1'b1;
      periodHit <= wrap;
      if (wrap) begin
        shadowHi <= dutyHiR;
        shadowLo <= dutyLoR;
        pwmOut   <= (dutyNew != '0);
      end else if (clearHit) begin
        pwmOut <= 1'b0;
      end
    end
  end

  assign shadowDuty = shadowHi;
  assign timerCount = tmr;
  assign ctrlReg    = {{(TMR_W-CTRL_W){1'b0}}, ctrlBits};
endmodule

// File: rtl/pwm10_top.sv
module pwm10_top
  import pwm10_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [TMR_W-1:0]  wrData,
  input  logic              flagClr,
  output logic              pwmOut,
  output logic              periodHit,
  output logic              irqFlag,
  output logic [TMR_W-1:0]  shadowDuty,
  output logic [TMR_W-1:0]  timerCount,
  output logic [TMR_W-1:0]  ctrlReg
);
  pwmStrobe_t        strobe;
  logic              tmrWr, wrap, timerOn;
  logic [1:0]        psSel;
  logic [POST_W-1:0] postSel;

  pwm10_ctrl #(.POST_W(POST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .timerOn(timerOn), .psSel(psSel),
    .postSel(postSel), .tmrWr(tmrWr), .wrap(wrap), .flagClr(flagClr),
    .strobe(strobe), .irqFlag(irqFlag)
  );

  pwm10_dp #(.TMR_W(TMR_W), .POST_W(POST_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .tmrWr(tmrWr), .wrap(wrap), .timerOn(timerOn),
    .psSel(psSel), .postSel(postSel), .pwmOut(pwmOut), .periodHit(periodHit),
    .shadowDuty(shadowDuty), .timerCount(timerCount), .ctrlReg(ctrlReg)
  );
endmodule

// File: rtl/pwm10_chk.sv
module pwm10_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             flagClr,
  input logic             pwmOut,
  input logic             periodHit,
  input logic             irqFlag,
  input logic [TMR_W-1:0] shadowDuty,
  input logic [TMR_W-1:0] timerCount,
  input logic [TMR_W-1:0] ctrlReg
);
  a_r7_hit_single: assert property (@(posedge clk) disable iff (!rstN)
    periodHit |=> !periodHit);

  a_r7_rise_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> periodHit);

  a_r6_shadow_at_match: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shadowDuty) |-> periodHit);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[2] && !$past(ctrlReg[2]) && !$past(wrEn))
      |-> ($stable(timerCount) && $stable(pwmOut)));

  a_r10_top_bit_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[TMR_W-1]);
endmodule

bind pwm10_top pwm10_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .flagClr(flagClr), .pwmOut(pwmOut),
  .periodHit(periodHit), .irqFlag(irqFlag), .shadowDuty(shadowDuty),
  .timerCount(timerCount), .ctrlReg(ctrlReg)
);

// File: tb/test_pwm10_top.sv
module test_pwm10_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       flagClr = 1'b0;
  logic       pwmOut, periodHit, irqFlag;
  logic [7:0] shadowDuty, timerCount, ctrlReg;

  int nCmp = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  pwm10_top i_pwm10_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .flagClr(flagClr), .pwmOut(pwmOut), .periodHit(periodHit),
    .irqFlag(irqFlag), .shadowDuty(shadowDuty), .timerCount(timerCount),
    .ctrlReg(ctrlReg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setDuty(input int d);
    wr(3'd1, 8'(d >> 2));
    wr(3'd2, 8'(d & 3));
  endtask

  task automatic waitHit();
    @(negedge clk);
    while (!periodHit) @(negedge clk);
  endtask

  // Called at a negedge where periodHit is high; returns at the next one.
  task automatic measure(output int hi, output int tot, output int midShadow,
                         input int wrAt, input logic [7:0] wrVal);
    hi = 0; tot = 0; midShadow = -1;
    do begin
      if (pwmOut) hi++;
      tot++;
      if (tot == wrAt + 2) midShadow = int'(shadowDuty);
      if (tot == wrAt) begin
        wrEn = 1'b1; wrAddr = 3'd1; wrData = wrVal;
      end else begin
        wrEn = 1'b0;
      end
      @(negedge clk);
    end while (!periodHit);
    wrEn = 1'b0;
  endtask

  task automatic runCase(input int ratio, input int pr, input int d);
    int hi, tot, ms, full, sel;
    sel  = (ratio == 1) ? 0 : (ratio == 4) ? 1 : 2;
    full = 4 * (pr + 1);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'(pr));
    setDuty(d);
    wr(3'd3, 8'(4 + sel));
    @(negedge clk);
    waitHit();
    measure(hi, tot, ms, -10, 8'h00);
    chk($sformatf("R2 period r=%0d pr=%0d", ratio, pr), tot, full * ratio);
    if (d == 0)
      chk($sformatf("R4 high r=%0d pr=%0d d=0", ratio, pr), hi, 0);
    else if (d >= full)
      chk($sformatf("R5 high r=%0d pr=%0d d=%0d", ratio, pr, d), hi, full * ratio);
    else
      chk($sformatf("R3 high r=%0d pr=%0d d=%0d", ratio, pr, d), hi, d * ratio);
    chk("R6 shadow readback", int'(shadowDuty), d >> 2);
  endtask

  task automatic sweep(input int ratio, input int pr);
    int full;
    int duties[8];
    full = 4 * (pr + 1);
    duties = '{0, 1, 2, 3, 5, full - 1, full, 1023};
    foreach (duties[k]) runCase(ratio, pr, duties[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int hi, tot, ms, n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 timer reset", int'(timerCount), 0);
    chk("R1 ctrl reset", int'(ctrlReg), 0);
    chk("R1 output reset", int'(pwmOut), 0);
    chk("R1 flag reset", int'(irqFlag), 0);

    // Default period 0xFF at ratio 1
    setDuty(10);
    wr(3'd3, 8'h04);
    @(negedge clk);
    waitHit();
    measure(hi, tot, ms, -10, 8'h00);
    chk("R1 default period", tot, 1024);
    chk("R3 default high", hi, 10);

    sweep(1, 3);
    sweep(1, 7);
    sweep(4, 5);
    sweep(16, 2);

    // R6: mid-period duty rewrite (20 -> 8) at ratio 1, period 7
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'd7);
    setDuty(20);
    wr(3'd3, 8'h04);
    @(negedge clk);
    waitHit();
    measure(hi, tot, ms, 3, 8'd2);
    chk("R6 old duty kept", hi, 20);
    chk("R6 shadow mid-period", ms, 5);
    measure(hi, tot, ms, -10, 8'h00);
    chk("R6 new duty next period", hi, 8);
    chk("R6 shadow after match", int'(shadowDuty), 2);

    // R7: strobe width and output rising at the strobe
    waitHit();
    chk("R7 output high at hit", int'(pwmOut), 1);
    @(negedge clk);
    chk("R7 hit one clock", int'(periodHit), 0);

    // R8: postscaler 2 -> every third match
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'd3);
    wr(3'd3, 8'h14);
    @(negedge clk);
    while (!irqFlag) @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    chk("R8 flag cleared", int'(irqFlag), 0);
    n = 0;
    do begin
      @(negedge clk);
      if (periodHit) n++;
    end while (!irqFlag);
    chk("R8 matches per flag", n, 3);
    repeat (40) @(negedge clk);
    chk("R8 flag sticky", int'(irqFlag), 1);

    // R9: freeze while high
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'd9);
    setDuty(30);
    wr(3'd3, 8'h05);
    @(negedge clk);
    waitHit();
    repeat (50) @(negedge clk);
    wr(3'd3, 8'h01);
    begin
      int t0, p0;
      t0 = int'(timerCount);
      p0 = int'(pwmOut);
      repeat (200) @(negedge clk);
      chk("R9 timer frozen", int'(timerCount), t0);
      chk("R9 output frozen", int'(pwmOut), p0);
      chk("R9 output was high", p0, 1);
    end

    // R10: timer load and control readback
    wr(3'd4, 8'h42);
    chk("R10 timer load", int'(timerCount), 8'h42);
    wr(3'd3, 8'hFF);
    chk("R10 ctrl top bit", int'(ctrlReg), 8'h7F);
    wr(3'd3, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule